// File: doc/BRIEF.md
# Legacy DMA Controller Register Front End

This block is the programmed-I/O side of a four-channel legacy DMA controller. A host reaches it over a byte-wide port bus with an 8-bit port address, separate read and write strobes, write data and combinational read data. Through that bus it programs each channel's 16-bit start address, 16-bit transfer count, 8-bit page and mode fields. It also drives the command byte, the request flags, the mask bits and the status byte. The transfer engine reads the programmed values from the block's outputs and reports terminal count back on one pulse input per channel.

The 16-bit address and count registers sit behind 8-bit ports. Bytes are steered by one byte-pointer flip-flop that all eight of those ports share. Every access to those ports flips the pointer, and two control ports return it to the low byte. A per-channel enable output goes high when a channel is unmasked and still has work: autoinit is set, or the remaining count is nonzero. On terminal count a channel either reloads its count (autoinit) or drops it to zero.

Top module: `dma_rf`

## Requirements
- R1: After reset all channels are masked, chan_en is 0, the status byte reads 0x00, mode, command and page outputs are 0, and a count port reads 0xFF for both bytes.
- R2: Ports 0x00/0x02/0x04/0x06 reach the address register of channel port>>1, and ports 0x01/0x03/0x05/0x07 reach its count register. One shared pointer selects the low byte when set, the high byte when clear. It flips on every read or write of any of these eight ports.
- R3: A write to port 0x0C sets the byte pointer, so the next address or count access uses the low byte.
- R4: A count port reads the internal remaining count minus one. The internal count is loaded with the written count plus one. After a terminal count without autoinit the count reads 0xFFFF.
- R5: A read of port 0x08 returns the status byte: bits 3:0 are per-channel terminal-count flags, bits 7:4 per-channel request flags. The read clears bits 3:0 and leaves bits 7:4 unchanged. A terminal-count pulse in the same cycle still sets its flag.
- R6: A write to port 0x09 selects a channel with bits 1:0. It sets status bit channel+4 when bit 2 is 1 and clears it when bit 2 is 0.
- R7: A write to port 0x0A sets the mask of channel wdata[1:0] to wdata[2]. A write to port 0x0F sets the masks of channels 0 to 3 to wdata bits 0 to 3.
- R8: A write to port 0x0B stores wdata[7:2] as the mode of channel wdata[1:0]. The stored field is {mode[1:0] (0 demand, 1 single, 2 block, 3 cascade), decrement, autoinit, type[1:0]}, and it appears on ch_mode bits [6*ch+5 : 6*ch].
- R9: A write to page port 0x87, 0x83, 0x81 or 0x82 loads the page of channel 0, 1, 2 or 3, seen on ch_page[8*ch+7 : 8*ch]. A read of a page port returns that page.
- R10: chan_en[ch] is 1 exactly when channel ch is unmasked and either its autoinit bit is set or its remaining count is nonzero.
- R11: A terminal-count pulse on a channel with autoinit set reloads the remaining count to the programmed count plus one.
- R12: Reads of ports 0x0A and 0x0E return 0x00. Reads of any port not named in these requirements return 0xFF.
- R13: A write to port 0x0D sets the byte pointer, masks all channels, and clears the status byte and the command byte.
- R14: A write to port 0x08 stores the byte in the command register, driven on cmd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 8 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access (ignored when io_wr is high) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr, combinational |
| tc_in | input | 4 | Terminal-count pulse per channel from the transfer engine |
| chan_en | output | 4 | Per-channel enable |
| ch_addr | output | 64 | Programmed address, 16 bits per channel |
| ch_cnt | output | 64 | Programmed count, 16 bits per channel |
| ch_page | output | 32 | Page, 8 bits per channel |
| ch_mode | output | 24 | Mode field, 6 bits per channel |
| cmd_o | output | 8 | Command byte |

## Verification
Several properties are checked on every cycle:
- the byte pointer flips on each address or count access;
- a clear-pointer or master-clear write leaves the pointer on the low byte;
- after a status read with no terminal count pending, the low status nibble is zero;
- a request write lands on the selected status bit;
- mode and command writes appear on the outputs one cycle later;
- an all-mask or master-clear write forces every enable low.

Only the bench's scenarios show the byte-level behaviour. That covers the count read offset by one, a shared pointer split across two different channels' ports, autoinit reload versus drop to zero, the page port mapping, and the fixed read values of unused ports.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

    localparam int unsigned NCH    = 4;
    localparam int unsigned CHW    = $clog2(NCH);
    localparam int unsigned DW     = 8;
    localparam int unsigned IOA_W  = 8;
    localparam int unsigned WW     = 2 * DW;     // address and count width
    localparam int unsigned CNT_IW = WW + 1;     // internal count holds count+1
    localparam int unsigned MODE_W = DW - 2;

    localparam logic [IOA_W-1:0] P_STAT   = 8'h08;  // read status / write command
    localparam logic [IOA_W-1:0] P_REQ    = 8'h09;
    localparam logic [IOA_W-1:0] P_SMASK  = 8'h0A;
    localparam logic [IOA_W-1:0] P_MODE   = 8'h0B;
    localparam logic [IOA_W-1:0] P_CLRPTR = 8'h0C;
    localparam logic [IOA_W-1:0] P_MCLR   = 8'h0D;
    localparam logic [IOA_W-1:0] P_ZERO   = 8'h0E;
    localparam logic [IOA_W-1:0] P_AMASK  = 8'h0F;

    typedef struct packed {
        logic [1:0] kind;
        logic       dec;
        logic       autoi;
        logic [1:0] xfer;
    } mode_t;

    typedef struct packed {
        logic           ac_hit;
        logic           ac_acc;
        logic           ac_wr;
        logic           ac_is_cnt;
        logic [CHW-1:0] ac_ch;
        logic           stat_hit;
        logic           stat_rd;
        logic           cmd_wr;
        logic           req_wr;
        logic           smask_wr;
        logic           amask_wr;
        logic           mode_wr;
        logic           clr_ptr;
        logic           mclr;
        logic           zero_hit;
        logic           page_hit;
        logic           page_wr;
        logic [CHW-1:0] page_ch;
    } dec_t;

    function automatic logic [WW-1:0] put_byte(input logic [WW-1:0] old,
                                               input logic lo,
                                               input logic [DW-1:0] b);
        return lo ? {old[WW-1:DW], b} : {b, old[DW-1:0]};
    endfunction

endpackage

// File: rtl/dma_rf_dec.sv
module dma_rf_dec
    import dma_rf_pkg::*;
(
    input  logic [IOA_W-1:0] io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    output dec_t             dec
);
    logic rd_eff;

    always_comb begin
        rd_eff = io_rd & ~io_wr;
        dec = '0;
        dec.ac_hit    = (io_addr < IOA_W'(2 * NCH));
        dec.ac_acc    = dec.ac_hit & (io_wr | rd_eff);
        dec.ac_wr     = dec.ac_hit & io_wr;
        dec.ac_is_cnt = io_addr[0];
        dec.ac_ch     = io_addr[CHW:1];
        dec.stat_hit  = (io_addr == P_STAT);
        dec.stat_rd   = dec.stat_hit & rd_eff;
        dec.cmd_wr    = dec.stat_hit & io_wr;
        dec.req_wr    = (io_addr == P_REQ) & io_wr;
        dec.smask_wr  = (io_addr == P_SMASK) & io_wr;
        dec.amask_wr  = (io_addr == P_AMASK) & io_wr;
        dec.mode_wr   = (io_addr == P_MODE) & io_wr;
        dec.clr_ptr   = (io_addr == P_CLRPTR) & io_wr;
        dec.mclr      = (io_addr == P_MCLR) & io_wr;
        dec.zero_hit  = (io_addr == P_SMASK) | (io_addr == P_ZERO);
        case (io_addr)
            8'h87: begin dec.page_hit = 1'b1; dec.page_ch = CHW'(0); end
            8'h83: begin dec.page_hit = 1'b1; dec.page_ch = CHW'(1); end
            8'h81: begin dec.page_hit = 1'b1; dec.page_ch = CHW'(2); end
            8'h82: begin dec.page_hit = 1'b1; dec.page_ch = CHW'(3); end
            default: begin dec.page_hit = 1'b0; dec.page_ch = '0; end
        endcase
        dec.page_wr = dec.page_hit & io_wr;
    end
endmodule

// File: rtl/dma_rf_ctl.sv
module dma_rf_ctl
    import dma_rf_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ac_acc,
    input  logic           clr_ptr,
    input  logic           mclr,
    input  logic           stat_rd,
    input  logic           req_wr,
    input  logic           cmd_wr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] tc,
    output logic           ptr_lo,
    output logic [DW-1:0]  status,
    output logic [DW-1:0]  cmd
);
    typedef struct packed {
        logic           ptr;
        logic [NCH-1:0] req;
        logic [NCH-1:0] tcf;
        logic [DW-1:0]  cmd;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ac_acc)             st_d.ptr = ~st_q.ptr;
        if (clr_ptr || mclr)    st_d.ptr = 1'b1;
        if (stat_rd)            st_d.tcf = '0;
        st_d.tcf = st_d.tcf | tc;
        if (req_wr)             st_d.req[wdata[CHW-1:0]] = wdata[2];
        if (cmd_wr)             st_d.cmd = wdata;
        if (mclr) begin
            st_d.tcf = '0;
            st_d.req = '0;
            st_d.cmd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ptr <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_lo = st_q.ptr;
    assign status = {st_q.req, st_q.tcf};
    assign cmd    = st_q.cmd;
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
    import dma_rf_pkg::*;
#(
    parameter int unsigned ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ac_wr,
    input  logic              ac_is_cnt,
    input  logic [CHW-1:0]    ac_ch,
    input  logic              lo_sel,
    input  logic [DW-1:0]     wdata,
    input  logic              page_wr,
    input  logic [CHW-1:0]    page_ch,
    input  logic              mode_wr,
    input  logic              smask_wr,
    input  logic              amask_wr,
    input  logic              mclr,
    input  logic              tc,
    output logic [WW-1:0]     base_addr,
    output logic [WW-1:0]     base_cnt,
    output logic [CNT_IW-1:0] rem_cnt,
    output logic [DW-1:0]     page,
    output mode_t             mode,
    output logic              enable
);
    typedef struct packed {
        logic [WW-1:0]     addr;
        logic [WW-1:0]     bcnt;
        logic [CNT_IW-1:0] rem;
        logic [DW-1:0]     page;
        mode_t             mode;
        logic              masked;
    } ch_t;

    ch_t st_d, st_q;
    logic me_ac, me_sel;

    always_comb begin
        me_ac  = ac_wr && (ac_ch == CHW'(ID));
        me_sel = (wdata[CHW-1:0] == CHW'(ID));
        st_d   = st_q;
        if (tc)
            st_d.rem = st_q.mode.autoi ? ({1'b0, st_q.bcnt} + CNT_IW'(1)) : '0;
        if (me_ac && !ac_is_cnt)
            st_d.addr = put_byte(st_q.addr, lo_sel, wdata);
        if (me_ac && ac_is_cnt) begin
            st_d.bcnt = put_byte(st_q.bcnt, lo_sel, wdata);
            st_d.rem  = {1'b0, st_d.bcnt} + CNT_IW'(1);
        end
        if (page_wr && (page_ch == CHW'(ID)))
            st_d.page = wdata;
        if (mode_wr && me_sel)
            st_d.mode = mode_t'(wdata[DW-1:2]);
        if (smask_wr && me_sel)
            st_d.masked = wdata[2];
        if (amask_wr)
            st_d.masked = wdata[ID];
        if (mclr)
            st_d.masked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.masked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_addr = st_q.addr;
    assign base_cnt  = st_q.bcnt;
    assign rem_cnt   = st_q.rem;
    assign page      = st_q.page;
    assign mode      = st_q.mode;
    assign enable    = !st_q.masked && (st_q.mode.autoi || (st_q.rem != '0));
endmodule

// File: rtl/dma_rf.sv
module dma_rf
    import dma_rf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IOA_W-1:0]      io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [DW-1:0]         io_wdata,
    output logic [DW-1:0]         io_rdata,
    input  logic [NCH-1:0]        tc_in,
    output logic [NCH-1:0]        chan_en,
    output logic [NCH*WW-1:0]     ch_addr,
    output logic [NCH*WW-1:0]     ch_cnt,
    output logic [NCH*DW-1:0]     ch_page,
    output logic [NCH*MODE_W-1:0] ch_mode,
    output logic [DW-1:0]         cmd_o
);
    dec_t              dec;
    logic              ptr_w;
    logic [DW-1:0]     status_w;
    logic [WW-1:0]     addr_v [NCH];
    logic [CNT_IW-1:0] rem_v  [NCH];
    logic [DW-1:0]     page_v [NCH];

    dma_rf_dec u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .dec     (dec)
    );

    dma_rf_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ac_acc  (dec.ac_acc),
        .clr_ptr (dec.clr_ptr),
        .mclr    (dec.mclr),
        .stat_rd (dec.stat_rd),
        .req_wr  (dec.req_wr),
        .cmd_wr  (dec.cmd_wr),
        .wdata   (io_wdata),
        .tc      (tc_in),
        .ptr_lo  (ptr_w),
        .status  (status_w),
        .cmd     (cmd_o)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        mode_t m;
        dma_rf_chan #(.ID(i)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ac_wr     (dec.ac_wr),
            .ac_is_cnt (dec.ac_is_cnt),
            .ac_ch     (dec.ac_ch),
            .lo_sel    (ptr_w),
            .wdata     (io_wdata),
            .page_wr   (dec.page_wr),
            .page_ch   (dec.page_ch),
            .mode_wr   (dec.mode_wr),
            .smask_wr  (dec.smask_wr),
            .amask_wr  (dec.amask_wr),
            .mclr      (dec.mclr),
            .tc        (tc_in[i]),
            .base_addr (addr_v[i]),
            .base_cnt  (ch_cnt[i*WW +: WW]),
            .rem_cnt   (rem_v[i]),
            .page      (page_v[i]),
            .mode      (m),
            .enable    (chan_en[i])
        );
        assign ch_addr[i*WW +: WW]         = addr_v[i];
        assign ch_page[i*DW +: DW]         = page_v[i];
        assign ch_mode[i*MODE_W +: MODE_W] = m;
    end

    logic [CNT_IW-1:0] cnt_m1;
    logic [WW-1:0]     word;

    always_comb begin
        cnt_m1 = rem_v[dec.ac_ch] - CNT_IW'(1);
        word   = dec.ac_is_cnt ? cnt_m1[WW-1:0] : addr_v[dec.ac_ch];
        if (dec.ac_hit)
            io_rdata = ptr_w ? word[DW-1:0] : word[WW-1:DW];
        else if (dec.stat_hit)
            io_rdata = status_w;
        else if (dec.zero_hit)
            io_rdata = '0;
        else if (dec.page_hit)
            io_rdata = page_v[dec.page_ch];
        else
            io_rdata = '1;
    end
endmodule

// File: rtl/dma_rf_chk.sv
module dma_rf_chk
    import dma_rf_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [IOA_W-1:0]      io_addr,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic [DW-1:0]         io_wdata,
    input logic [NCH-1:0]        tc_in,
    input logic [NCH-1:0]        chan_en,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [DW-1:0]         cmd_o,
    input logic                  ptr_w,
    input logic [DW-1:0]         status_w
);
    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && io_addr < IOA_W'(2 * NCH)) |=> (ptr_w != $past(ptr_w)));

    // R3
    clr_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_CLRPTR) |=> ptr_w);

    // R5
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == P_STAT && tc_in == '0) |=> (status_w[NCH-1:0] == '0));

    // R6
    req_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_REQ) |=>
        (status_w[NCH + 32'($past(io_wdata[CHW-1:0]))] == $past(io_wdata[2])));

    // R7
    all_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_AMASK && io_wdata[NCH-1:0] == {NCH{1'b1}}) |=> (chan_en == '0));

    // R8
    mode_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_MODE) |=>
        (ch_mode[32'($past(io_wdata[CHW-1:0])) * MODE_W +: MODE_W] == $past(io_wdata[DW-1:2])));

    // R13
    master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_MCLR) |=> (chan_en == '0 && cmd_o == '0 && status_w == '0 && ptr_w));

    // R14
    cmd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_STAT) |=> (cmd_o == $past(io_wdata)));
endmodule

bind dma_rf dma_rf_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .tc_in    (tc_in),
    .chan_en  (chan_en),
    .ch_mode  (ch_mode),
    .cmd_o    (cmd_o),
    .ptr_w    (ptr_w),
    .status_w (status_w)
);

// File: tb/tb_dma_rf.sv
`timescale 1ns/1ps
module tb_dma_rf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  tc_in = '0;
    logic [3:0]  chan_en;
    logic [63:0] ch_addr;
    logic [63:0] ch_cnt;
    logic [31:0] ch_page;
    logic [23:0] ch_mode;
    logic [7:0]  cmd_o;

    int n_chk = 0;
    int n_fail = 0;
    logic smp = 1'b0;
    logic done = 1'b0;

    // kind: 0 io_rdata, 1 chan_en, 2 cmd_o, 3 ch_mode, 4 ch_page
    int          kq[$];
    logic [31:0] eq[$];
    string       tq[$];

    always #10 clk = ~clk;   // 50 MHz

    dma_rf dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .tc_in(tc_in), .chan_en(chan_en),
        .ch_addr(ch_addr), .ch_cnt(ch_cnt), .ch_page(ch_page), .ch_mode(ch_mode),
        .cmd_o(cmd_o)
    );

    // monitor: samples 8 ns after the driving edge, well before the next rising edge
    always begin
        @(negedge clk);
        #8;
        if (smp && kq.size() > 0) begin
            int k;
            logic [31:0] e, a;
            string t;
            k = kq.pop_front(); e = eq.pop_front(); t = tq.pop_front();
            case (k)
                0: a = {24'h0, io_rdata};
                1: a = {28'h0, chan_en};
                2: a = {24'h0, cmd_o};
                3: a = {8'h0, ch_mode};
                default: a = ch_page;
            endcase
            n_chk++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic drive(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d,
                         input logic [3:0] tc, input int k, input logic [31:0] e, input string t);
        @(negedge clk);
        io_wr = w; io_rd = r; io_addr = a; io_wdata = d; tc_in = tc;
        smp = (k >= 0);
        if (k >= 0) begin kq.push_back(k); eq.push_back(e); tq.push_back(t); end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        drive(1'b1, 1'b0, a, d, 4'h0, -1, 0, "");
    endtask
    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        drive(1'b0, 1'b1, a, 8'h00, 4'h0, 0, {24'h0, e}, t);
    endtask
    task automatic pulse_tc(input logic [3:0] tc);
        drive(1'b0, 1'b0, 8'hFF, 8'h00, tc, -1, 0, "");
    endtask
    task automatic chk(input int k, input logic [31:0] e, input string t);
        drive(1'b0, 1'b0, 8'hFF, 8'h00, 4'h0, k, e, t);
    endtask

    initial begin
        #200_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        chk(1, 32'h0, "R1 chan_en after reset");
        chk(3, 32'h0, "R1 mode after reset");
        rd(8'h08, 8'h00, "R1 status after reset");
        rd(8'h01, 8'hFF, "R1 R4 count low after reset");
        rd(8'h01, 8'hFF, "R1 R4 count high after reset");
        // byte pointer sequencing
        wr(8'h00, 8'h34); wr(8'h00, 8'h12);
        rd(8'h00, 8'h34, "R2 addr low");
        rd(8'h00, 8'h12, "R2 addr high");
        wr(8'h04, 8'h78); wr(8'h05, 8'h9A);
        wr(8'h0C, 8'h00);
        rd(8'h05, 8'h00, "R2 R4 shared pointer count low");
        rd(8'h05, 8'h9A, "R2 R4 shared pointer count high");
        rd(8'h04, 8'h78, "R2 ch2 addr low");
        rd(8'h04, 8'h00, "R2 ch2 addr high");
        // clear pointer
        wr(8'h00, 8'h55); wr(8'h0C, 8'h00);
        rd(8'h00, 8'h55, "R3 low after clear");
        rd(8'h00, 8'h12, "R3 high after clear");
        // count and enable
        wr(8'h01, 8'h10); wr(8'h01, 8'h00);
        wr(8'h0A, 8'h00);
        chk(1, 32'h1, "R10 ch0 enabled with count");
        rd(8'h01, 8'h10, "R4 count minus one low");
        rd(8'h01, 8'h00, "R4 count minus one high");
        // terminal count, no autoinit
        pulse_tc(4'h1);
        chk(1, 32'h0, "R10 R4 disabled after terminal count");
        rd(8'h08, 8'h01, "R5 tc flag");
        rd(8'h08, 8'h00, "R5 tc flag cleared by read");
        rd(8'h01, 8'hFF, "R4 count after tc low");
        rd(8'h01, 8'hFF, "R4 count after tc high");
        // requests
        wr(8'h09, 8'h06);
        pulse_tc(4'h2);
        rd(8'h08, 8'h42, "R6 R5 request and tc");
        rd(8'h08, 8'h40, "R5 request kept after read");
        wr(8'h09, 8'h02);
        rd(8'h08, 8'h00, "R6 request cleared");
        // mode and autoinit
        wr(8'h0B, 8'h59);
        chk(3, 32'h580, "R8 mode fields ch1");
        chk(1, 32'h0, "R10 masked autoinit channel off");
        wr(8'h0A, 8'h01);
        chk(1, 32'h2, "R10 autoinit enables with zero count");
        wr(8'h0C, 8'h00); wr(8'h03, 8'h05); wr(8'h03, 8'h00);
        pulse_tc(4'h2);
        chk(1, 32'h2, "R11 still enabled after autoinit tc");
        rd(8'h03, 8'h05, "R11 reload low");
        rd(8'h03, 8'h00, "R11 reload high");
        // masks
        wr(8'h0F, 8'h00);
        chk(1, 32'h6, "R7 R10 all unmasked");
        wr(8'h0F, 8'h04);
        chk(1, 32'h2, "R7 all-mask bit2");
        wr(8'h0A, 8'h05);
        chk(1, 32'h0, "R7 single mask ch1");
        // pages
        wr(8'h87, 8'hA0); wr(8'h83, 8'hA1); wr(8'h81, 8'hA2); wr(8'h82, 8'hA3);
        chk(4, 32'hA3A2A1A0, "R9 page mapping");
        rd(8'h81, 8'hA2, "R9 page readback");
        // fixed reads
        rd(8'h0A, 8'h00, "R12 port 0x0A");
        rd(8'h0E, 8'h00, "R12 port 0x0E");
        rd(8'h0B, 8'hFF, "R12 port 0x0B");
        rd(8'h90, 8'hFF, "R12 port 0x90");
        // command
        wr(8'h08, 8'h04);
        chk(2, 32'h04, "R14 command stored");
        // master clear
        wr(8'h0F, 8'h00);
        chk(1, 32'h6, "R13 pre unmask");
        wr(8'h0C, 8'h00); wr(8'h00, 8'h66); wr(8'h09, 8'h07);
        wr(8'h0D, 8'h00);
        chk(1, 32'h0, "R13 all masked");
        chk(2, 32'h0, "R13 command cleared");
        rd(8'h08, 8'h00, "R13 status cleared");
        rd(8'h00, 8'h66, "R13 pointer on low byte");
        chk(-1, 0, "");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule